// File: doc/BRIEF.md
# Masked Latched Alarm Interrupt Controller

This block collects sixteen event and status sources into one latched alarm word and signals a host through a single active-low, open-drain alert line. Each source passes through a per-bit enable before it can set its latched bit. A set latched bit stays set until the host clears it by writing a 1 to it. The alert line is modelled as an output-enable: while it is high, the pad is pulled low. Sources may be steady levels or one-cycle pulses. Pulses are caught into sticky bits, so the host does not have to watch for them.

Two bits do not follow the plain pattern, and each is handled by a small state machine. The charger-detector bit uses the toggle tracker. This machine keeps a reference level in state REF_LOW or REF_HIGH. When the debounced detector level differs from the reference, the LOW_TO_HIGH or HIGH_TO_LOW transition fires. That transition raises a one-cycle toggle event and moves the reference to the new level. The power-on bit uses the power-on tracker. It starts in POR_PENDING after reset and takes the EXIT_SEEN transition to POR_CLEARED when the config-update-exit strobe arrives. It then stays in POR_CLEARED until the next reset.

A register port with three addresses gives the host access to the raw word, the latched word and the enable mask. During reset the mask loads from a configuration input. Reset is synchronous and active low.

Top module: `alarm_latch_ctrl`

## Requirements
- R1: `alert_oe_o` is 1 exactly when at least one latched status bit is 1. It drops only after a host clear write.
- R2: A source whose mask bit is 0 never sets its latched bit and never drives the alert.
- R3: The raw word (address 0) reads the present source values regardless of the mask. Bits 13..0 are `src_i`, bit 14 is the charger-detector level and bit 15 is the power-on flag.
- R4: Writing the latched word (address 1) clears each bit written with 1. Bits written with 0 keep their value.
- R5: A one-cycle pulse on an enabled source leaves its latched bit set until the host clears it.
- R6: Latched bit 14 is set when the detector level differs from the stored reference level. The reference then takes the new level, so each change is flagged exactly once.
- R7: During reset the mask (address 2) loads `dflt_mask_i`. Latched bits reset to 0. A write to address 2 replaces the mask, and the new mask can be read back.
- R8: The power-on flag is 1 after reset and becomes 0 on the cycle after `cfg_exit_i`. When bit 15 is enabled, the flag latches into latched bit 15.
- R9: If a set condition and a host clear hit the same bit in the same cycle, the bit ends up set.
- R10: A clear write to a bit whose enabled level source is still asserted leaves the bit set and the alert asserted.
- R11: Address 3 reads 0. Writes to addresses 0 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 14 | Plain sources, bits 13..0 of the alarm word, levels or pulses |
| chg_det_i | input | 1 | Debounced charger-detector level |
| cfg_exit_i | input | 1 | Config-update-exit strobe; clears the power-on flag |
| dflt_mask_i | input | 16 | Mask value loaded during reset |
| bus_addr_i | input | 2 | Register address: 0 raw, 1 latched, 2 mask, 3 unused |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register, combinational |
| alert_oe_o | output | 1 | Alert pull-down enable (1 drives the line low) |

## Verification
The hardest case to reach is a host clear and a fresh set landing on the same bit in the same edge. A related case is a clear aimed at a bit whose enabled level source has not gone away. In both, the bit must survive, and the alert must stay low in the same cycle. The stimulus table holds the source high while it writes the clear in the same vector, and checks that the bit is still latched. A later vector clears a mixed word in which only the pulse bit's source has ended. The toggle tracker's once-per-change rule is reached by clearing bit 14 while the detector level is held, and then confirming that no second flag appears.

// File: rtl/alarm_pkg.sv
`timescale 1ns/1ps
package alarm_pkg;
    localparam int NUM_BITS  = 16;
    localparam int NUM_PLAIN = 14;
    localparam int IDX_CHG   = 14;
    localparam int IDX_POR   = 15;

    typedef enum logic [1:0] {
        REG_RAW   = 2'd0,
        REG_LATCH = 2'd1,
        REG_MASK  = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_t;

    typedef enum logic {
        REF_LOW  = 1'b0,
        REF_HIGH = 1'b1
    } ref_state_t;

    typedef enum logic {
        POR_PENDING = 1'b0,
        POR_CLEARED = 1'b1
    } por_state_t;
endpackage

// File: rtl/alarm_toggle_det.sv
`timescale 1ns/1ps
module alarm_toggle_det
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic toggle_o
);
    ref_state_t state_q, state_d;

    // State register: reference level, seeded from the level during reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= lvl_i ? REF_HIGH : REF_LOW;
        else        state_q <= state_d;
    end

    // Outputs and next state
    always_comb begin
        state_d  = state_q;
        toggle_o = 1'b0;
        unique case (state_q)
            REF_LOW: begin
                if (lvl_i) begin          // LOW_TO_HIGH
                    toggle_o = 1'b1;
                    state_d  = REF_HIGH;
                end
            end
            REF_HIGH: begin
                if (!lvl_i) begin         // HIGH_TO_LOW
                    toggle_o = 1'b1;
                    state_d  = REF_LOW;
                end
            end
            default: state_d = REF_LOW;
        endcase
    end

    assert_toggle_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_o |=> (!toggle_o || (lvl_i != $past(lvl_i))));
endmodule

// File: rtl/alarm_por_flag.sv
`timescale 1ns/1ps
module alarm_por_flag
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_exit_i,
    output logic flag_o
);
    por_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= POR_PENDING;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        flag_o  = 1'b0;
        unique case (state_q)
            POR_PENDING: begin
                flag_o = 1'b1;
                if (cfg_exit_i) state_d = POR_CLEARED;   // EXIT_SEEN
            end
            POR_CLEARED: flag_o = 1'b0;
            default:     state_d = POR_CLEARED;
        endcase
    end

    assert_por_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_exit_i |=> !flag_o);
    assert_por_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_o |=> !flag_o);
endmodule

// File: rtl/alarm_status_bank.sv
`timescale 1ns/1ps
module alarm_status_bank #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] lat_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic lat_q;

        // set has priority over clear so no event is lost
        always_ff @(posedge clk) begin
            if (!rst_n)        lat_q <= 1'b0;
            else if (set_i[b]) lat_q <= 1'b1;
            else if (clr_i[b]) lat_q <= 1'b0;
        end
        assign lat_o[b] = lat_q;

        assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_q && !clr_i[b]) |=> lat_q);
        assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !set_i[b]) |=> !lat_q);
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> lat_q);
    end
endmodule

// File: rtl/alarm_latch_ctrl.sv
`timescale 1ns/1ps
module alarm_latch_ctrl
    import alarm_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PLAIN-1:0] src_i,
    input  logic                 chg_det_i,
    input  logic                 cfg_exit_i,
    input  logic [NUM_BITS-1:0]  dflt_mask_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic                 bus_wr_i,
    input  logic [NUM_BITS-1:0]  bus_wdata_i,
    output logic [NUM_BITS-1:0]  bus_rdata_o,
    output logic                 alert_oe_o
);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(REG_RAW);
    localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(REG_LATCH);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(REG_MASK);

    logic                toggle_evt;
    logic                por_flag;
    logic [NUM_BITS-1:0] raw_word;
    logic [NUM_BITS-1:0] set_vec;
    logic [NUM_BITS-1:0] clr_vec;
    logic [NUM_BITS-1:0] lat_vec;
    logic [NUM_BITS-1:0] mask_q;
    logic                wr_mask;
    logic                wr_latch;

    alarm_toggle_det u_toggle (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (chg_det_i),
        .toggle_o (toggle_evt)
    );

    alarm_por_flag u_por (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_exit_i (cfg_exit_i),
        .flag_o     (por_flag)
    );

    assign raw_word = {por_flag, chg_det_i, src_i};

    // The latch-side source differs from the raw view only for the detector bit
    always_comb begin
        set_vec          = {por_flag, toggle_evt, src_i};
        set_vec          = set_vec & mask_q;
    end

    assign wr_mask  = bus_wr_i && (bus_addr_i == A_MASK);
    assign wr_latch = bus_wr_i && (bus_addr_i == A_LATCH);
    assign clr_vec  = wr_latch ? bus_wdata_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= dflt_mask_i;
        else if (wr_mask) mask_q <= bus_wdata_i;
    end

    alarm_status_bank #(.WIDTH(NUM_BITS)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .lat_o (lat_vec)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_RAW:   bus_rdata_o = raw_word;
            A_LATCH: bus_rdata_o = lat_vec;
            A_MASK:  bus_rdata_o = mask_q;
            default: bus_rdata_o = '0;
        endcase
    end

    assign alert_oe_o = |lat_vec;

    assert_mask_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat_vec & ~$past(lat_vec) & ~$past(mask_q)) == '0));
    assert_alert_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_oe_o) |-> ($past(set_vec) != '0));
    assert_alert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_oe_o && !wr_latch) |=> alert_oe_o);
    assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_q == $past(bus_wdata_i)));
endmodule

// File: tb/alarm_latch_ctrl_tb.sv
`timescale 1ns/1ps
module alarm_latch_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] src = '0;
    logic        chg = 1'b0;
    logic        cfg_exit = 1'b0;
    logic [15:0] dflt_mask = 16'h7F0F;
    logic [1:0]  addr = 2'd0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        alert;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alarm_latch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .chg_det_i(chg),
        .cfg_exit_i(cfg_exit), .dflt_mask_i(dflt_mask), .bus_addr_i(addr),
        .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .alert_oe_o(alert)
    );

    // vector: src[14] chg[1] wr[1] addr[2] wdata[16] expected latched[16]
    localparam int NV = 19;
    localparam int VW = 50;
    localparam logic [VW-1:0] VECS [NV] = '{
        {14'h0001, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0001}, // R5 level latches
        {14'h0000, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0001}, // R5 sticky
        {14'h0010, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0001}, // R2 bit4 masked
        {14'h0100, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0101}, // R5 pulse bit8
        {14'h0000, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0101}, // R5 pulse held
        {14'h0000, 1'b0, 1'b1, 2'd1, 16'h0001, 16'h0100}, // R4 clear bit0 only
        {14'h0001, 1'b0, 1'b1, 2'd1, 16'h0001, 16'h0101}, // R9 set beats clear
        {14'h0001, 1'b0, 1'b1, 2'd1, 16'h0101, 16'h0001}, // R10 level survives
        {14'h0000, 1'b0, 1'b1, 2'd1, 16'hFFFF, 16'h0000}, // R4 clear all
        {14'h0000, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h4000}, // R6 rise flagged
        {14'h0000, 1'b1, 1'b1, 2'd1, 16'h4000, 16'h0000}, // R6 clear
        {14'h0000, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000}, // R6 no re-flag
        {14'h0000, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h4000}, // R6 fall flagged
        {14'h0000, 1'b0, 1'b1, 2'd1, 16'h4000, 16'h0000}, // R6 clear
        {14'h0000, 1'b0, 1'b1, 2'd2, 16'h00F0, 16'h0000}, // R7 new mask
        {14'h0011, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0010}, // R2 R7 new mask used
        {14'h0000, 1'b0, 1'b1, 2'd1, 16'h0010, 16'h0000}, // R4
        {14'h0000, 1'b0, 1'b1, 2'd0, 16'hFFFF, 16'h0000}, // R11 raw write ignored
        {14'h1000, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0000}  // R2 bit12 masked
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [13:0] s, input logic c, input logic x,
                       input logic w, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        src = s; chg = c; cfg_exit = x; wr = w; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr = 1'b0; cfg_exit = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    initial begin
        logic [15:0] v;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // reset state
        rd(2'd2, v); chk("R7 reset mask", v, 16'h7F0F);
        rd(2'd1, v); chk("R7 reset latched", v, 16'h0000);
        chk("R1 reset alert", {15'd0, alert}, 16'h0000);
        rd(2'd0, v); chk("R3 R8 reset raw", v, 16'h8000);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] e;
            e = VECS[i];
            cyc(e[49:36], e[35], 1'b0, e[34], e[33:32], e[31:16]);
            rd(2'd1, v);
            chk($sformatf("R4/R5/R6 vector %0d latched", i), v, e[15:0]);
            chk($sformatf("R1 vector %0d alert", i), {15'd0, alert}, {15'd0, (e[15:0] != 16'h0)});
        end

        // R7 R11: mask kept after write to raw address
        rd(2'd2, v); chk("R7 R11 mask readback", v, 16'h00F0);
        cyc(14'h0, 1'b0, 1'b0, 1'b1, 2'd3, 16'hFFFF);
        rd(2'd3, v); chk("R11 unused reads 0", v, 16'h0000);
        rd(2'd2, v); chk("R11 mask untouched", v, 16'h00F0);
        rd(2'd1, v); chk("R11 latched untouched", v, 16'h0000);

        // R3: raw view regardless of mask, read inside a half cycle
        @(negedge clk);
        src = 14'h2AAA; chg = 1'b1; addr = 2'd0;
        #1; chk("R3 raw view", rdata, 16'hEAAA);
        src = 14'h0;

        // R8: power-on flag latches when enabled
        cyc(14'h0, 1'b1, 1'b0, 1'b1, 2'd2, 16'h8000);
        cyc(14'h0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0);
        rd(2'd1, v); chk("R8 power-on latched", v, 16'h8000);
        chk("R1 alert on power-on", {15'd0, alert}, 16'h0001);
        cyc(14'h0, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0);
        rd(2'd0, v); chk("R8 flag cleared by exit", v, 16'h4000);
        cyc(14'h0, 1'b1, 1'b0, 1'b1, 2'd1, 16'h8000);
        cyc(14'h0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0);
        rd(2'd1, v); chk("R8 no re-latch after exit", v, 16'h0000);
        chk("R1 alert released", {15'd0, alert}, 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule